// File: doc/BRIEF.md
# SPI Host Serial Engine

This block is the bit-level engine of an SPI host. It is configured through a single configuration word. It takes 8-bit words from an external transmit queue and sends them on MOSI, most significant bit first. At the same time it assembles the bits sampled on MISO into a received word, which it hands to an external receive queue. It generates SCLK from the reference clock with a programmable power-of-two divider, supports all four clock polarity and phase combinations, and drives four select lines. These lines carry either a one-hot active-low select or a raw 4-bit device code.

A global enable input gates all activity. Clock polarity and phase are captured only when that enable goes from low to high, so SCLK never moves unexpectedly while the engine runs. A word starts on its own whenever the transmit queue holds data. In manual mode, a word starts only when the configuration word is written with its trigger bit set.

Top module: `spi_host_engine`

## Requirements
- R1: Synchronous reset, active high, leaves SCLK low, MOSI low, all select lines high, and no receive or pop pulse. The configuration resets to 0x7C09: master enable on, divisor 1, select field 0xF, force on.
- R2: The divisor field is configuration bits 5:3 and holds a value n, with 0 treated as 1. Each SCLK level during a word lasts 1<<n reference cycles, so the SCLK period is 2<<n cycles. The value is captured when a word starts, and the first SCLK edge comes 1<<n cycles after the select asserts.
- R3: With the phase bit (bit 2) clear, MOSI shows bit 7 when the word begins and advances one bit at SCLK edges 2, 4, …, 14. MISO is sampled at edges 1, 3, …, 15.
- R4: With the phase bit set, MOSI shows bit 7 from the word start and advances at edges 3, 5, …, 15. MISO is sampled at edges 2, 4, …, 16.
- R5: The received word is presented with a one-cycle rx_valid pulse that coincides with SCLK edge 16. The first sampled bit is the most significant.
- R6: The SCLK idle level equals the captured polarity (bit 1). Polarity and phase are copied from the configuration only in the cycle where en_i rises. Writes made while enabled have no effect until then.
- R7: When en_i is low or master enable (bit 0) is clear, the engine stops within one cycle. SCLK returns to idle, all select lines go high, a word in flight is discarded without an rx_valid pulse, and no new word starts.
- R8: With manual start (bit 15) clear, a word starts when the engine is idle, enabled since the previous cycle, and tx_valid_i is high. tx_pop_o pulses for one cycle in the cycle after the start.
- R9: With manual start set, a word starts only after a configuration write that has both bit 15 and bit 16 set. Each such write launches one word, and bit 16 is never stored.
- R10: With force (bit 14) clear, the select lines show the value derived from the select field (bits 13:10) while a word is in flight. From the cycle SCLK begins the word through the cycle of edge 16 they are otherwise all high.
- R11: With force set, the select lines show the derived value whenever the engine is enabled, whether or not a word is in flight.
- R12: With decode (bit 9) clear, only the lowest-numbered zero bit of the select field is driven low, and a field of 0xF selects nothing. With decode set, the field is driven unchanged as a device code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Global enable |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 17 | Configuration write data, bit 16 is the start trigger |
| tx_valid_i | input | 1 | Transmit queue holds a word |
| tx_data_i | input | DATA_W | Head word of the transmit queue |
| tx_pop_o | output | 1 | Removes the head word from the transmit queue |
| rx_valid_o | output | 1 | Received word is valid for one cycle |
| rx_data_o | output | DATA_W | Received word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Select lines or device code |

## Verification
The hardest states to reach from the ports are these three: a word cut off part way by a dropped enable, a polarity written while enabled but not yet applied, and a manual-mode engine waiting with data queued but no trigger. The stimulus writes the new mode mid-session and runs a full word on the old mode. It then pulses en_i low to apply the new mode. It drops the enable about twenty cycles into a word, and it queues a word under manual start before any trigger. A behavioural model follows every cycle against a pseudo-random MISO stream, so sampling edges and bit order are checked for every mode and divisor.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // configuration word layout
  localparam int CFG_W    = 16;
  localparam int CFG_IN_W = 17;
  localparam int DIV_W    = 3;
  localparam int CS_W     = 4;
  localparam int B_MSTR   = 0;
  localparam int B_CPOL   = 1;
  localparam int B_CPHA   = 2;
  localparam int B_DIV_LO = 3;
  localparam int B_DEC    = 9;
  localparam int B_SS_LO  = 10;
  localparam int B_FORCE  = 14;
  localparam int B_MAN    = 15;
  localparam int B_TRIG   = 16;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h7C09;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_t;
endpackage

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = (CNT_W'(1) << div_i) - CNT_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2: the caller never passes a divisor of zero, so edges are at least two cycles apart
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tick_i,
  input  logic [EDGE_W-1:0] edge_i,
  input  logic              cpha_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam logic [EDGE_W-1:0] LAST = EDGE_W'(2 * DATA_W - 1);

  logic [DATA_W-2:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] rx_nxt;
  logic              sample;
  logic              adv;

  assign sample = (edge_i[0] == cpha_i);
  assign adv    = !sample && (edge_i != '0) && (edge_i != LAST);
  assign rx_nxt = {rx_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q       <= '0;
      rx_q       <= '0;
      mosi_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (load_i) begin
        tx_q   <= tx_byte_i[DATA_W-2:0];
        mosi_o <= tx_byte_i[DATA_W-1];
        rx_q   <= '0;
      end else if (tick_i) begin
        if (sample) rx_q <= rx_nxt;
        if (adv) begin
          mosi_o <= tx_q[DATA_W-2];
          tx_q   <= tx_q << 1;
        end
        if (edge_i == LAST) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= sample ? rx_nxt : rx_q;
        end
      end
    end
  end

  // R3: MOSI only moves on a word load or an SCLK edge
  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> $stable(mosi_o));
  // R5: a word takes many cycles, so the valid pulse never repeats back to back
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/spi_cs_gen.sv
module spi_cs_gen #(
  parameter int CS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active_i,
  input  logic            select_i,
  input  logic            decode_i,
  input  logic [CS_W-1:0] field_i,
  output logic [CS_W-1:0] cs_n_o
);
  logic [CS_W-1:0] pick;
  logic [CS_W-1:0] val;

  always_comb begin
    pick = '1;
    for (int i = CS_W - 1; i >= 0; i--) begin
      if (!field_i[i]) pick = ~(CS_W'(1) << i);
    end
  end

  assign val = decode_i ? field_i : pick;

  always_ff @(posedge clk) begin
    if (rst)                      cs_n_o <= '1;
    else if (active_i && select_i) cs_n_o <= val;
    else                          cs_n_o <= '1;
  end

  // R12: in one-hot mode at most one line is low
  a_r12_single_line: assert property (@(posedge clk) disable iff (rst)
    !$past(decode_i) |-> ($countones(~cs_n_o) <= 1));
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic                cfg_wr_i,
  input  logic [CFG_IN_W-1:0] cfg_wdata_i,
  input  logic                tx_valid_i,
  input  logic [DATA_W-1:0]   tx_data_i,
  output logic                tx_pop_o,
  output logic                rx_valid_o,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic                sclk_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic [CS_W-1:0]     cs_n_o
);
  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * DATA_W - 1);

  logic [CFG_W-1:0]  cfg_q;
  logic              en_q;
  logic              cpol_a, cpha_a;
  eng_state_t        state_q, state_nxt;
  logic [EDGE_W-1:0] edge_q;
  logic [DIV_W-1:0]  div_q, div_eff;
  logic              trig_q;
  logic              run, en_rise, go, tick, last;
  logic              unused_cfg;

  assign unused_cfg = ^cfg_q[8:6];
  assign run        = en_i && cfg_q[B_MSTR];
  assign en_rise    = en_i && !en_q;
  assign go         = (state_q == ST_IDLE) && run && en_q && tx_valid_i &&
                      (!cfg_q[B_MAN] || trig_q);
  assign div_eff    = (cfg_q[B_DIV_LO +: DIV_W] == '0) ? DIV_W'(1)
                                                      : cfg_q[B_DIV_LO +: DIV_W];
  assign last       = tick && (edge_q == EDGE_LAST);

  always_comb begin
    state_nxt = state_q;
    if (!run)      state_nxt = ST_IDLE;
    else if (go)   state_nxt = ST_SHIFT;
    else if (last) state_nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= CFG_RST;
      en_q     <= 1'b0;
      cpol_a   <= CFG_RST[B_CPOL];
      cpha_a   <= CFG_RST[B_CPHA];
      state_q  <= ST_IDLE;
      edge_q   <= '0;
      div_q    <= DIV_W'(1);
      trig_q   <= 1'b0;
      tx_pop_o <= 1'b0;
      sclk_o   <= 1'b0;
    end else begin
      en_q     <= en_i;
      state_q  <= state_nxt;
      tx_pop_o <= go;
      if (cfg_wr_i) cfg_q <= cfg_wdata_i[CFG_W-1:0];
      if (en_rise) begin
        cpol_a <= cfg_q[B_CPOL];
        cpha_a <= cfg_q[B_CPHA];
      end
      if (cfg_wr_i && cfg_wdata_i[B_TRIG] && cfg_wdata_i[B_MAN]) trig_q <= 1'b1;
      else if (go || !cfg_q[B_MAN])                             trig_q <= 1'b0;
      if (go) begin
        div_q  <= div_eff;
        edge_q <= '0;
      end else if (tick) begin
        edge_q <= edge_q + EDGE_W'(1);
      end
      if (!run || state_q == ST_IDLE) sclk_o <= cpol_a;
      else if (tick)                  sclk_o <= ~sclk_o;
    end
  end

  spi_edge_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (run && (state_q == ST_SHIFT)),
    .div_i (div_q),
    .tick_o(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (go),
    .tx_byte_i (tx_data_i),
    .tick_i    (tick),
    .edge_i    (edge_q),
    .cpha_i    (cpha_a),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_valid_o(rx_valid_o),
    .rx_data_o (rx_data_o)
  );

  spi_cs_gen #(.CS_W(CS_W)) u_cs (
    .clk     (clk),
    .rst     (rst),
    .active_i(run),
    .select_i(cfg_q[B_FORCE] || (state_nxt == ST_SHIFT)),
    .decode_i(cfg_q[B_DEC]),
    .field_i (cfg_q[B_SS_LO +: CS_W]),
    .cs_n_o  (cs_n_o)
  );

  // R7: a low enable releases every select line in the next cycle
  a_r7_cs_release: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cs_n_o == '1));
  // R6: captured polarity and phase only change after an enable rise
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !en_rise |=> $stable({cpol_a, cpha_a}));
  // R8: the pop strobe is a single-cycle pulse
  a_r8_pop_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_pop_o |=> !tx_pop_o);
  // R9: an untriggered manual engine stays idle
  a_r9_wait_trigger: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_MAN] && !trig_q && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: tb/spi_host_engine_bench.sv
`timescale 1ns/1ps
module spi_host_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic miso = 1'b0;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_pop, rx_valid, sclk, mosi;
  logic [7:0] rx_data;
  logic [3:0] cs_n;

  always #5 clk = ~clk;

  logic [7:0] tq [0:15];
  int tq_head = 0, tq_tail = 0;
  assign tx_valid = (tq_head != tq_tail);
  assign tx_data  = tq[tq_head % 16];

  spi_host_engine u_spi_host_engine (
    .clk(clk), .rst(rst), .en_i(en), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n)
  );

  int checks = 0, errs = 0, n_rx = 0, n_pop = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5B;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_cfg;
  bit m_enq, m_cpol, m_cpha, m_busy, m_sclk, m_mosi, m_rxv, m_pop, m_trig;
  int m_half, m_cnt, m_edge, m_k, m_rx, m_rxd;
  logic [7:0] m_txb;
  logic [3:0] m_cs;

  always @(posedge clk) begin : model
    bit run, go;
    int d;
    logic [3:0] fld, sel;
    if (rst) begin
      m_cfg = 16'h7C09; m_enq = 0; m_cpol = 0; m_cpha = 0; m_busy = 0;
      m_sclk = 0; m_mosi = 0; m_rxv = 0; m_pop = 0; m_trig = 0;
      m_half = 2; m_cnt = 0; m_edge = 0; m_k = 0; m_rx = 0; m_rxd = 0;
      m_txb = 0; m_cs = 4'hF;
    end else begin
      run = en && m_cfg[0];
      go = !m_busy && run && m_enq && tx_valid && (!m_cfg[15] || m_trig);
      m_pop = go;
      m_rxv = 0;
      if (!run) begin
        m_busy = 0; m_sclk = m_cpol;
      end else if (go) begin
        d = int'(m_cfg[5:3]);
        if (d == 0) d = 1;
        m_half = 1 << d; m_cnt = 0; m_edge = 0; m_busy = 1;
        m_txb = tx_data; m_k = 0; m_mosi = tx_data[7]; m_rx = 0; m_sclk = m_cpol;
      end else if (m_busy) begin
        if (m_cnt == m_half - 1) begin
          m_cnt = 0;
          m_sclk = !m_sclk;
          if ((m_edge % 2) == int'(m_cpha)) m_rx = ((m_rx << 1) | int'(miso)) & 255;
          else if (m_edge != 0 && m_edge != 15) begin
            m_k++;
            m_mosi = m_txb[7 - m_k];
          end
          if (m_edge == 15) begin
            m_rxv = 1; m_rxd = m_rx; m_busy = 0;
          end
          m_edge++;
        end else m_cnt++;
      end else m_sclk = m_cpol;
      fld = m_cfg[13:10];
      if (m_cfg[9]) sel = fld;
      else begin
        sel = 4'hF;
        for (int i = 0; i < 4; i++) if (!fld[i]) begin
          sel = 4'hF ^ (4'b1 << i);
          break;
        end
      end
      if (!run) m_cs = 4'hF;
      else if (m_cfg[14] || m_busy) m_cs = sel;
      else m_cs = 4'hF;
      if (cfg_wr && cfg_wdata[16] && cfg_wdata[15]) m_trig = 1;
      else if (go || !m_cfg[15]) m_trig = 0;
      if (en && !m_enq) begin
        m_cpol = m_cfg[1]; m_cpha = m_cfg[2];
      end
      m_enq = en;
      if (cfg_wr) m_cfg = cfg_wdata[15:0];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(sclk == m_sclk, "R2 R6 sclk", sclk, m_sclk);
      chk(mosi == m_mosi, "R3 R4 mosi", mosi, m_mosi);
      chk(cs_n == m_cs, "R10 R11 R12 cs_n", cs_n, m_cs);
      chk(rx_valid == m_rxv, "R5 rx_valid", rx_valid, m_rxv);
      chk(tx_pop == m_pop, "R8 tx_pop", tx_pop, m_pop);
      if (rx_valid && m_rxv) chk(int'(rx_data) == m_rxd, "R5 rx_data", rx_data, m_rxd);
      if (rx_valid) n_rx++;
      if (tx_pop) begin
        n_pop++;
        tq_head++;
      end
    end
    miso = lfsr[0];
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errs++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    tq[tq_tail % 16] = b;
    tq_tail++;
  endtask

  task automatic toggle_en();
    en = 1'b0;
    cyc(2);
    en = 1'b1;
    cyc(3);
  endtask

  initial begin : stim
    int base;
    cyc(3);
    // R1 reset state
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    chk(mosi == 1'b0 && !rx_valid && !tx_pop, "R1 outputs", {mosi, rx_valid, tx_pop}, 0);
    rst = 1'b0;
    en = 1'b1;
    cyc(2);
    // R8 R10 auto start, mode 0, divisor 1
    wr(17'h03809);
    push(8'hA5); push(8'h3C);
    cyc(100);
    chk(n_rx == 2, "R8 two words received", n_rx, 2);
    // R6 mode written while enabled: idle level unchanged
    wr(17'h0380F);
    push(8'h96);
    cyc(60);
    chk(sclk == 1'b0, "R6 polarity held until enable rise", sclk, 0);
    toggle_en();
    chk(sclk == 1'b1, "R6 polarity applied after enable rise", sclk, 1);
    // R4 mode 3, divisor 3
    wr(17'h0381F);
    push(8'h5A); push(8'hC3);
    cyc(600);
    // R3 mode 2
    wr(17'h0380B);
    toggle_en();
    push(8'h81);
    cyc(80);
    // R2 divisor 7 and divisor 0
    wr(17'h03839);
    toggle_en();
    push(8'h7E);
    cyc(2200);
    wr(17'h03801);
    push(8'h42);
    cyc(80);
    chk(n_rx == 8, "R2 all words received", n_rx, 8);
    // R11 R12 forced select, one-hot and decoded
    wr(17'h05409);
    cyc(3);
    chk(cs_n == 4'hD, "R12 one-hot lowest zero", cs_n, 4'hD);
    wr(17'h05609);
    cyc(3);
    chk(cs_n == 4'h5, "R11 R12 forced decoded code", cs_n, 4'h5);
    // R10 auto select, decoded
    wr(17'h00E09);
    cyc(3);
    chk(cs_n == 4'hF, "R10 idle select released", cs_n, 4'hF);
    push(8'h18);
    cyc(12);
    chk(cs_n == 4'h3, "R10 select during word", cs_n, 4'h3);
    cyc(40);
    // R9 manual start
    wr(17'h0B809);
    base = n_pop;
    push(8'hE7);
    cyc(50);
    chk(n_pop == base, "R9 no start without trigger", n_pop, base);
    wr(17'h1B809);
    cyc(50);
    chk(n_pop == base + 1, "R9 one word per trigger", n_pop, base + 1);
    // R7 abort mid word
    wr(17'h03809);
    push(8'hB4);
    cyc(20);
    base = n_rx;
    en = 1'b0;
    cyc(40);
    chk(n_rx == base, "R7 aborted word not delivered", n_rx, base);
    chk(cs_n == 4'hF && sclk == 1'b0, "R7 lines idle while disabled", {cs_n, sclk}, 5'h1E);
    en = 1'b1;
    // R7 master enable clear
    wr(17'h03808);
    base = n_pop;
    push(8'h99);
    cyc(60);
    chk(n_pop == base, "R7 master enable blocks start", n_pop, base);
    wr(17'h03809);
    cyc(60);
    chk(n_pop == base + 1, "R7 start after master enable", n_pop, base + 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule